// File: doc/BRIEF.md
# ADC Result Block-Transfer Engine

This block sits between an analog-to-digital conversion controller and on-chip memory. Each time the converter presents a result-ready strobe with a 16-bit result, the engine gives that result a word address and writes it to memory through a simple write port with a ready handshake. Addresses advance by one 16-bit word per transfer. A per-block transfer count sets the size of each block, and a count of zero turns the engine off.

Software sets a start address, a per-block count and two mode bits. One mode bit picks a single block or two back-to-back blocks (ping-pong). The other picks whether the engine stops when the pass is complete or wraps to the start address and keeps going. A one-cycle pulse marks the end of each block. A status bit shows which of the two blocks is being filled, so software can service the other one. A one-entry holding buffer absorbs a result that arrives while a memory write is still stalled. Any further result in that window is dropped and raises a sticky overrun flag.

Top module: `adc_xfer_engine`

## Requirements
- R1: While the per-block count is 0 the engine is disabled: incoming results cause no memory write.
- R2: Writing the start address or the count restarts the engine. The pointer goes to the start address, the block counter reloads from the count, the first block is selected and overrun clears. After reset the start address is 0x200, the count is 0, all outputs are low and no write is pending.
- R3: Each accepted result is written as one word carrying that result's data. Successive results go to addresses that rise by 2, in arrival order.
- R4: In single-block mode with continuous operation off, exactly count results are written. Later results are ignored until the next restart.
- R5: In two-block mode the second block follows the first without a gap, starting at start + 2*count. With continuous operation off, the engine stops after 2*count writes.
- R6: `active_blk` is 0 while the first block is being filled and 1 while the second block is being filled. It returns to 0 when a pass ends.
- R7: With continuous operation on, the engine wraps to the start address after the last block of a pass and runs without end. If continuous is cleared, the engine completes the current pass and then stops.
- R8: `blk_done` pulses high for one cycle, in the cycle after memory accepts the last word of a block. It does not pulse for any other word.
- R9: While `mem_we` is high and `mem_ready` is low, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R10: A result that arrives while a write is pending is held in a one-entry buffer. If that buffer is also full, the result is dropped without using an address, and `overrun` sets and stays set until the next restart.
- R11: A result that arrives in the same cycle as a restart is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_wr | input | 1 | Start-address register write strobe |
| start_val | input | 16 | Start address to write |
| count_wr | input | 1 | Per-block count register write strobe |
| count_val | input | 8 | Transfers per block (0 = disabled) |
| mode_wr | input | 1 | Mode bits write strobe |
| mode_two_blk | input | 1 | 1 = two consecutive blocks, 0 = one block |
| mode_cont | input | 1 | 1 = continuous operation |
| res_valid | input | 1 | Conversion result ready strobe |
| res_data | input | 16 | Conversion result |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| blk_done | output | 1 | One-cycle block completion pulse |
| active_blk | output | 1 | Block currently being filled |
| overrun | output | 1 | Sticky result-dropped flag |

## Verification
The bench probes the edge of each block. It checks that exactly count words land and that the next result is refused. A design with an off-by-one in the counter would write one word too many or too few, or would place the second ping-pong block one word off from start + 2*count. It checks that a continuous pass wraps back to the start address, and that clearing the continuous bit in the middle of a pass still lets that pass finish. It also stalls memory while three results arrive. A design that lets a dropped result use up an address would leave a hole, and one that forgets the holding buffer would lose the second result. Results that arrive in the same cycle as a restart, and restarts in the middle of a block, are also checked for stray writes.

// File: rtl/adc_xfer_pkg.sv
package adc_xfer_pkg;
  localparam int unsigned XF_AW = 16;
  localparam int unsigned XF_DW = 16;

  typedef logic [XF_AW-1:0] xf_addr_t;
  typedef logic [XF_DW-1:0] xf_data_t;

  // one queued memory write: where, what, and whether it closes a block
  typedef struct packed {
    xf_addr_t addr;
    xf_data_t data;
    logic     last;
  } xf_entry_t;
endpackage

// File: rtl/adc_xfer_cfg.sv
module adc_xfer_cfg
  import adc_xfer_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter xf_addr_t    RESET_ADDR = 16'h0200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr,
  input  xf_addr_t         start_val,
  input  logic             count_wr,
  input  logic [CNT_W-1:0] count_val,
  input  logic             mode_wr,
  input  logic             mode_two_blk,
  input  logic             mode_cont,
  output xf_addr_t         start_q,
  output logic [CNT_W-1:0] count_q,
  output logic             two_q,
  output logic             cont_q,
  output logic             restart,
  output xf_addr_t         start_ld,
  output logic [CNT_W-1:0] count_ld
);
  xf_addr_t         start_d;
  logic [CNT_W-1:0] count_d;
  logic             two_d, cont_d;

  always_comb begin
    start_d  = start_wr ? start_val : start_q;
    count_d  = count_wr ? count_val : count_q;
    two_d    = mode_wr  ? mode_two_blk : two_q;
    cont_d   = mode_wr  ? mode_cont    : cont_q;
    restart  = start_wr | count_wr;
    start_ld = start_d;
    count_ld = count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= RESET_ADDR;
      count_q <= '0;
      two_q   <= 1'b0;
      cont_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      count_q <= count_d;
      two_q   <= two_d;
      cont_q  <= cont_d;
    end
  end

  // R2
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_wr |=> $stable(start_q));
  // R2
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_wr |=> count_q == $past(count_val));
endmodule

// File: rtl/adc_xfer_seq.sv
module adc_xfer_seq
  import adc_xfer_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  xf_addr_t         start_ld,
  input  logic [CNT_W-1:0] count_ld,
  input  xf_addr_t         start_q,
  input  logic [CNT_W-1:0] count_q,
  input  logic             two_q,
  input  logic             cont_q,
  input  logic             res_valid,
  input  xf_data_t         res_data,
  input  logic             room,
  output logic             want,
  output logic             take,
  output xf_entry_t        entry,
  output logic             active_blk
);
  localparam xf_addr_t STEP = xf_addr_t'(XF_DW / 8);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  xf_addr_t         ptr_q, ptr_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             blk_q, blk_d;
  logic             armed_q, armed_d;
  logic             blk_end, pass_end;

  always_comb begin
    want     = res_valid & armed_q & ~restart;
    take     = want & room;
    blk_end  = (rem_q == ONE);
    pass_end = blk_end & (~two_q | blk_q);

    entry.addr = ptr_q;
    entry.data = res_data;
    entry.last = blk_end;

    ptr_d   = ptr_q;
    rem_d   = rem_q;
    blk_d   = blk_q;
    armed_d = armed_q;
    if (restart) begin
      ptr_d   = start_ld;
      rem_d   = count_ld;
      blk_d   = 1'b0;
      armed_d = (count_ld != '0);
    end else if (take) begin
      ptr_d = ptr_q + STEP;
      if (pass_end) begin
        blk_d = 1'b0;
        if (cont_q) begin
          ptr_d   = start_q;
          rem_d   = count_q;
          armed_d = (count_q != '0);
        end else begin
          armed_d = 1'b0;
        end
      end else if (blk_end) begin
        blk_d = 1'b1;
        rem_d = count_q;
      end else begin
        rem_d = rem_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      rem_q   <= '0;
      blk_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      rem_q   <= rem_d;
      blk_q   <= blk_d;
      armed_q <= armed_d;
    end
  end

  assign active_blk = blk_q;

  // R1
  armed_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> rem_q != '0);
  // R6
  single_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !two_q && !restart) |=> !blk_q);
endmodule

// File: rtl/adc_xfer_wq.sv
module adc_xfer_wq
  import adc_xfer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      restart,
  input  logic      want,
  input  logic      take,
  input  xf_entry_t in_entry,
  input  logic      mem_ready,
  output logic      room,
  output xf_addr_t  mem_addr,
  output xf_data_t  mem_wdata,
  output logic      mem_we,
  output logic      blk_done,
  output logic      overrun
);
  xf_entry_t stg_q, stg_d, buf_q, buf_d;
  logic      stg_vld_q, stg_vld_d, buf_vld_q, buf_vld_d;
  logic      ovr_q, ovr_d, done_q, done_d;
  logic      wr_done;

  always_comb begin
    wr_done   = stg_vld_q & mem_ready;
    room      = ~stg_vld_q | ~buf_vld_q | wr_done;
    stg_d     = stg_q;
    stg_vld_d = stg_vld_q;
    buf_d     = buf_q;
    buf_vld_d = buf_vld_q;
    if (wr_done) begin
      if (buf_vld_q) begin
        stg_d     = buf_q;
        stg_vld_d = 1'b1;
        if (take) buf_d = in_entry;
        else      buf_vld_d = 1'b0;
      end else if (take) begin
        stg_d = in_entry;
      end else begin
        stg_vld_d = 1'b0;
      end
    end else if (take) begin
      if (!stg_vld_q) begin
        stg_d     = in_entry;
        stg_vld_d = 1'b1;
      end else begin
        buf_d     = in_entry;
        buf_vld_d = 1'b1;
      end
    end
    ovr_d  = restart ? 1'b0 : (ovr_q | (want & ~room));
    done_d = wr_done & stg_q.last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_vld_q <= 1'b0;
      buf_vld_q <= 1'b0;
      ovr_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      stg_vld_q <= stg_vld_d;
      buf_vld_q <= buf_vld_d;
      ovr_q     <= ovr_d;
      done_q    <= done_d;
    end
  end

  // data registers: no reset, loaded only when their entry changes
  always_ff @(posedge clk) begin
    if (wr_done | take) stg_q <= stg_d;
    if (take)           buf_q <= buf_d;
  end

  assign mem_addr  = stg_q.addr;
  assign mem_wdata = stg_q.data;
  assign mem_we    = stg_vld_q;
  assign blk_done  = done_q;
  assign overrun   = ovr_q;

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_ready) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata)));
  // R10
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !restart) |=> overrun);
  // R10
  buf_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_vld_q |-> stg_vld_q);
  // R8
  done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> $past(mem_we && mem_ready));
endmodule

// File: rtl/adc_xfer_engine.sv
module adc_xfer_engine
  import adc_xfer_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter xf_addr_t    RESET_ADDR = 16'h0200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr,
  input  logic [XF_AW-1:0] start_val,
  input  logic             count_wr,
  input  logic [CNT_W-1:0] count_val,
  input  logic             mode_wr,
  input  logic             mode_two_blk,
  input  logic             mode_cont,
  input  logic             res_valid,
  input  logic [XF_DW-1:0] res_data,
  output logic [XF_AW-1:0] mem_addr,
  output logic [XF_DW-1:0] mem_wdata,
  output logic             mem_we,
  input  logic             mem_ready,
  output logic             blk_done,
  output logic             active_blk,
  output logic             overrun
);
  xf_addr_t         start_q, start_ld;
  logic [CNT_W-1:0] count_q, count_ld;
  logic             two_q, cont_q, restart;
  logic             want, take, room;
  xf_entry_t        entry;

  adc_xfer_cfg #(.CNT_W(CNT_W), .RESET_ADDR(RESET_ADDR)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .start_wr(start_wr), .start_val(start_val),
    .count_wr(count_wr), .count_val(count_val),
    .mode_wr(mode_wr), .mode_two_blk(mode_two_blk), .mode_cont(mode_cont),
    .start_q(start_q), .count_q(count_q), .two_q(two_q), .cont_q(cont_q),
    .restart(restart), .start_ld(start_ld), .count_ld(count_ld)
  );

  adc_xfer_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .start_ld(start_ld), .count_ld(count_ld),
    .start_q(start_q), .count_q(count_q), .two_q(two_q), .cont_q(cont_q),
    .res_valid(res_valid), .res_data(res_data), .room(room),
    .want(want), .take(take), .entry(entry), .active_blk(active_blk)
  );

  adc_xfer_wq u_wq (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .want(want), .take(take), .in_entry(entry), .mem_ready(mem_ready),
    .room(room), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .blk_done(blk_done), .overrun(overrun)
  );

  // R3
  take_issues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> mem_we);
  // R11
  restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !mem_we) |=> !mem_we);
endmodule

// File: tb/test_adc_xfer_engine.sv
module test_adc_xfer_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk, rst_n;
  logic        start_wr, count_wr, mode_wr, mode_two_blk, mode_cont;
  logic [15:0] start_val;
  logic [7:0]  count_val;
  logic        res_valid, mem_ready;
  logic [15:0] res_data, mem_addr, mem_wdata;
  logic        mem_we, blk_done, active_blk, overrun;

  int checks = 0, errors = 0;
  int wr_n = 0, done_n = 0;
  logic [15:0] log_addr [0:63];
  logic [15:0] log_data [0:63];

  adc_xfer_engine i_adc_xfer_engine (
    .clk(clk), .rst_n(rst_n),
    .start_wr(start_wr), .start_val(start_val),
    .count_wr(count_wr), .count_val(count_val),
    .mode_wr(mode_wr), .mode_two_blk(mode_two_blk), .mode_cont(mode_cont),
    .res_valid(res_valid), .res_data(res_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_ready(mem_ready), .blk_done(blk_done), .active_blk(active_blk),
    .overrun(overrun)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: log each accepted write, count completion pulses
  always @(posedge clk) begin
    if (rst_n && mem_we && mem_ready) begin
      if (wr_n < 64) begin
        log_addr[wr_n] <= mem_addr;
        log_data[wr_n] <= mem_wdata;
      end
      wr_n <= wr_n + 1;
    end
    if (rst_n && blk_done) done_n <= done_n + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_wr(input string req, input int idx, input logic [15:0] a, input logic [15:0] d);
    chk(req, {16'h0, log_addr[idx]}, {16'h0, a});
    chk(req, {16'h0, log_data[idx]}, {16'h0, d});
  endtask

  task automatic set_start(input logic [15:0] v);
    @(negedge clk); start_wr = 1'b1; start_val = v;
    @(negedge clk); start_wr = 1'b0;
  endtask

  task automatic set_count(input logic [7:0] v);
    @(negedge clk); count_wr = 1'b1; count_val = v;
    @(negedge clk); count_wr = 1'b0;
  endtask

  task automatic set_mode(input logic two, input logic cont);
    @(negedge clk); mode_wr = 1'b1; mode_two_blk = two; mode_cont = cont;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic send(input logic [15:0] d);
    @(negedge clk); res_valid = 1'b1; res_data = d;
    @(negedge clk); res_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    int b;
    chk("R2 reset mem_we", mem_we, 0);
    chk("R2 reset blk_done", blk_done, 0);
    chk("R2 reset active_blk", active_blk, 0);
    chk("R2 reset overrun", overrun, 0);
    b = wr_n;
    send(16'h1111);
    chk("R1 disabled after reset", wr_n - b, 0);
    set_count(8'd2);            // restart from reset start address
    send(16'hA001);
    chk("R2 reset start addr count", wr_n - b, 1);
    chk_wr("R2 reset start 0x200", b, 16'h0200, 16'hA001);
    set_count(8'd0);
    b = wr_n;
    send(16'h2222);
    send(16'h3333);
    chk("R1 count zero no writes", wr_n - b, 0);
  endtask

  task automatic t_single;
    int b, d0;
    set_mode(1'b0, 1'b0);
    set_start(16'h0300);
    set_count(8'd3);
    b = wr_n; d0 = done_n;
    for (int i = 0; i < 5; i++) send(16'hB000 + 16'(i));
    chk("R4 single block write count", wr_n - b, 3);
    for (int i = 0; i < 3; i++)
      chk_wr("R3 single block addr/data", b + i, 16'h0300 + 16'(2*i), 16'hB000 + 16'(i));
    chk("R8 one done per block", done_n - d0, 1);
  endtask

  task automatic t_done_timing;
    int b;
    set_mode(1'b0, 1'b0);
    set_count(8'd1);
    b = wr_n;
    @(negedge clk); res_valid = 1'b1; res_data = 16'hC0DE;
    @(negedge clk); res_valid = 1'b0;
    chk("R8 no pulse at accept", blk_done, 0);
    chk("R3 write issued", mem_we, 1);
    @(negedge clk);
    chk("R8 pulse after last word", blk_done, 1);
    @(negedge clk);
    chk("R8 pulse one cycle", blk_done, 0);
    chk("R4 count one single write", wr_n - b, 1);
  endtask

  task automatic t_two_blk;
    int b, d0;
    set_mode(1'b1, 1'b0);
    set_start(16'h0400);
    set_count(8'd2);
    b = wr_n; d0 = done_n;
    send(16'hD000);
    chk("R6 first block", active_blk, 0);
    send(16'hD001);
    chk("R6 second block", active_blk, 1);
    send(16'hD002);
    send(16'hD003);
    chk("R6 back to first", active_blk, 0);
    send(16'hD004);
    send(16'hD005);
    chk("R5 two block stops", wr_n - b, 4);
    for (int i = 0; i < 4; i++)
      chk_wr("R5 two block addr", b + i, 16'h0400 + 16'(2*i), 16'hD000 + 16'(i));
    chk("R8 done per block two", done_n - d0, 2);
  endtask

  task automatic t_cont;
    int b, d0;
    set_mode(1'b0, 1'b1);
    set_start(16'h0500);
    set_count(8'd2);
    b = wr_n; d0 = done_n;
    for (int i = 0; i < 5; i++) send(16'hE000 + 16'(i));
    chk("R7 cont writes", wr_n - b, 5);
    chk_wr("R7 wrap addr", b + 2, 16'h0500, 16'hE002);
    chk_wr("R7 wrap addr again", b + 4, 16'h0500, 16'hE004);
    chk("R8 cont done count", done_n - d0, 2);
    set_mode(1'b0, 1'b0);       // finish current pass then stop
    for (int i = 0; i < 3; i++) send(16'hE100 + 16'(i));
    chk("R7 cont clear finishes pass", wr_n - b, 6);
    chk_wr("R7 last pass word", b + 5, 16'h0502, 16'hE100);
    chk("R7 cont clear done", done_n - d0, 3);
  endtask

  task automatic t_restart;
    int b, d0;
    set_mode(1'b0, 1'b1);
    set_count(8'd4);
    set_start(16'h0700);
    b = wr_n; d0 = done_n;
    send(16'hF000);
    send(16'hF001);
    set_start(16'h0780);
    send(16'hF002);
    chk("R2 mid-block restart writes", wr_n - b, 3);
    chk_wr("R2 restart pointer", b + 2, 16'h0780, 16'hF002);
    chk("R2 restart no done", done_n - d0, 0);
    // result in the same cycle as a restart
    b = wr_n;
    @(negedge clk); start_wr = 1'b1; start_val = 16'h07A0; res_valid = 1'b1; res_data = 16'hBAD0;
    @(negedge clk); start_wr = 1'b0; res_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 same-cycle result ignored", wr_n - b, 0);
    send(16'hF003);
    chk_wr("R11 next result at new start", b, 16'h07A0, 16'hF003);
  endtask

  task automatic t_overrun;
    int b;
    set_mode(1'b0, 1'b0);
    set_start(16'h0600);
    set_count(8'd8);
    b = wr_n;
    @(negedge clk); mem_ready = 1'b0; res_valid = 1'b1; res_data = 16'h5A00;
    @(negedge clk); res_data = 16'h5A01;
    @(negedge clk); res_data = 16'h5A02;
    @(negedge clk); res_valid = 1'b0;
    chk("R10 overrun set", overrun, 1);
    repeat (3) @(negedge clk);
    chk("R9 held during stall", mem_we, 1);
    chk("R9 addr held", mem_addr, 16'h0600);
    chk("R9 data held", mem_wdata, 16'h5A00);
    chk("R10 overrun sticky", overrun, 1);
    mem_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 buffered result kept", wr_n - b, 2);
    chk_wr("R10 first", b, 16'h0600, 16'h5A00);
    chk_wr("R10 buffered", b + 1, 16'h0602, 16'h5A01);
    send(16'h5A03);
    chk_wr("R10 dropped used no address", b + 2, 16'h0604, 16'h5A03);
    set_count(8'd8);
    chk("R2 restart clears overrun", overrun, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    start_wr = 0; count_wr = 0; mode_wr = 0; mode_two_blk = 0; mode_cont = 0;
    start_val = '0; count_val = '0; res_valid = 0; res_data = '0; mem_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_done_timing();
    t_two_blk();
    t_cont();
    t_restart();
    t_overrun();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=%0d exp=0", WD_CYCLES);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule